// File: doc/BRIEF.md
# Channel Pair Fault Retry Controller

This block is the digital control for one pair of half-bridge output channels in a multi-channel PWM power stage. It passes the two PWM inputs to the gate-drive side and decides, cycle by cycle, whether each output is driving or held at high impedance. Current, temperature and supply sensing stay outside the block. Their results arrive as fault inputs, which pass through a two-flop synchronizer before use.

A 3-bit mode word is captured when the pair's reset input is released. It selects one of two recovery policies and whether the second channel's input is inverted internally, so that one PWM signal can drive a full bridge. Under the latched policy, a faulted channel stays off until the pair reset is cycled. Under the retry policy, the channel tries to re-enable at a fixed period. After a bounded number of failed attempts it falls back to the latched state.

After release, the outputs stay off until the startup condition is met. With ramping disabled, that condition is a count of rising edges on the first PWM input. With ramping enabled, the outputs start at once. Three active-low flags report over-current on either channel, the thermal warning, and over-temperature or under-voltage.

Top module: `pair_fault_guard`

## Requirements
- R1: While `pair_rst_n` is low, both `drv_en` bits are 0 and both `drv_out` bits are 0, whatever the PWM inputs do. Every channel state, retry count and startup count is cleared.
- R2: `mode_sel` and `ramp_en` are sampled on the first clock edge at which `pair_rst_n` is high. Later changes have no effect until the next release.
- R3: A captured mode with bit 2 set is reserved. Both `drv_en` bits then stay 0 for the whole release, with or without PWM edges or ramping.
- R4: With ramping disabled, outputs enable only after START_EDGES (default 35) rising edges of `pwm_in[0]` have been seen after release. With ramping enabled, outputs enable on the third clock edge after release, without any PWM edge.
- R5: When enabled, `drv_out[0]` follows `pwm_in[0]`. `drv_out[1]` follows `pwm_in[1]` if captured mode bit 1 is 0, and follows its inverse if that bit is 1. A disabled channel drives 0.
- R6: A channel's fault is its own `oc_fault` bit or the shared `ot_fault` or `uv_fault`. Once seen through the two-stage synchronizer, the channel disables on the next edge. An over-current on one channel leaves the other channel enabled.
- R7: With captured mode bit 0 set (latched policy), a faulted channel stays disabled after the fault clears, until `pair_rst_n` goes low and high again.
- R8: With mode bit 0 clear (retry policy), a faulted channel waits RETRY_CYC = (CLK_HZ/1000)*RETRY_MS cycles, then makes an attempt. If the fault is gone, the channel re-enables; otherwise it waits another period.
- R9: If the fault is still present when the wait expires, or returns during the one-cycle probe that follows, the attempt counts as failed. After MAX_TRIES (default 5) consecutive failed attempts, the channel latches off as in R7. A successful attempt clears the count.
- R10: `oc_flag_n` is low while either synchronized over-current bit is set, `tw_flag_n` is low while the warning is set, and `thr_flag_n` is low while over-temperature or under-voltage is set. Each flag follows its input two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pair_rst_n | input | 1 | Active-low reset of the channel pair; rising edge loads the mode |
| mode_sel | input | 3 | Mode word: bit 0 latched policy, bit 1 invert second input, bit 2 reserved |
| ramp_en | input | 1 | Ramping enabled: skips the PWM-edge startup count |
| pwm_in | input | 2 | PWM inputs of the two channels |
| oc_fault | input | 2 | Over-current fault per channel |
| ot_fault | input | 1 | Over-temperature fault, shared |
| uv_fault | input | 1 | Supply under-voltage fault, shared |
| tw_alert | input | 1 | Thermal warning |
| drv_out | output | 2 | Gated PWM to the gate drivers |
| drv_en | output | 2 | Output driving (1) or high impedance (0) per channel |
| oc_flag_n | output | 1 | Active-low over-current flag for the pair |
| tw_flag_n | output | 1 | Active-low thermal warning flag |
| thr_flag_n | output | 1 | Active-low over-temperature / under-voltage flag |

## Verification
The retry timer's expiry and the release of a fault can land in the same cycle. Which one wins decides whether an attempt succeeds or is counted as failed. The bench holds an over-current for a random length placed at a random offset inside a retry period. It keeps a margin of a few tens of cycles around each attempt instant, so the expected outcome is unambiguous. A bench function predicts the attempt on which the channel returns. The output must still be off just before that instant and driving just after it, and a fault spanning every attempt must end in the latched state.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [2:0] {
    CH_OFF,
    CH_RUN,
    CH_WAIT,
    CH_PROBE,
    CH_LATCH
  } ch_state_t;

  // Number of clock cycles in one retry interval.
  function automatic int unsigned retry_cycles(input int unsigned clk_hz,
                                               input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

  function automatic logic mode_reserved(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_latched(input logic [2:0] m);
    return m[0];
  endfunction

  function automatic logic mode_invert(input logic [2:0] m);
    return m[1];
  endfunction

  // PWM gating for one channel, with optional inversion.
  function automatic logic gate_pwm(input logic en, input logic pwm, input logic inv);
    return en & (pwm ^ inv);
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pfg_startup.sv
module pfg_startup #(
  parameter int unsigned START_EDGES = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bypass,
  input  logic pwm_in,
  output logic started
);

  localparam int CW = $clog2(START_EDGES + 1);

  logic          pwm_q;
  logic [CW-1:0] edge_cnt;
  logic          rise;

  assign rise = pwm_in & ~pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      edge_cnt <= '0;
      started  <= 1'b0;
    end else begin
      pwm_q <= pwm_in;
      if (!active) begin
        edge_cnt <= '0;
        started  <= 1'b0;
      end else if (bypass) begin
        started <= 1'b1;
      end else if (!started && rise) begin
        edge_cnt <= edge_cnt + 1'b1;
        if (edge_cnt == CW'(START_EDGES - 1)) started <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfg_chan.sv
module pfg_chan import pfg_pkg::*; #(
  parameter int unsigned RETRY_CYC = 1700,
  parameter int unsigned MAX_TRIES = 5,
  localparam int TMW = $clog2(RETRY_CYC),
  localparam int TW  = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_on,
  input  logic          start_ok,
  input  logic          latch_mode,
  input  logic          fault,
  output logic          en,
  output logic          latched,
  output logic [TW-1:0] tries
);

  ch_state_t      state;
  logic [TMW-1:0] timer;
  logic           expire;

  assign expire = (timer == TMW'(RETRY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CH_OFF;
      timer <= '0;
      tries <= '0;
    end else if (!pair_on) begin
      state <= CH_OFF;
      timer <= '0;
      tries <= '0;
    end else begin
      unique case (state)
        CH_OFF: begin
          if (start_ok) state <= CH_RUN;
        end
        CH_RUN: begin
          if (fault) begin
            timer <= '0;
            tries <= '0;
            state <= latch_mode ? CH_LATCH : CH_WAIT;
          end
        end
        CH_WAIT: begin
          if (!expire) begin
            timer <= timer + 1'b1;
          end else begin
            timer <= '0;
            if (!fault) begin
              state <= CH_PROBE;
            end else if (tries == TW'(MAX_TRIES - 1)) begin
              tries <= TW'(MAX_TRIES);
              state <= CH_LATCH;
            end else begin
              tries <= tries + 1'b1;
            end
          end
        end
        CH_PROBE: begin
          timer <= '0;
          if (!fault) begin
            tries <= '0;
            state <= CH_RUN;
          end else if (tries == TW'(MAX_TRIES - 1)) begin
            tries <= TW'(MAX_TRIES);
            state <= CH_LATCH;
          end else begin
            tries <= tries + 1'b1;
            state <= CH_WAIT;
          end
        end
        CH_LATCH: state <= CH_LATCH;
        default:  state <= CH_OFF;
      endcase
    end
  end

  assign en      = pair_on & ((state == CH_RUN) | (state == CH_PROBE));
  assign latched = (state == CH_LATCH);

endmodule

// File: rtl/pair_fault_guard.sv
module pair_fault_guard import pfg_pkg::*; #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned RETRY_MS    = 85,
  parameter int unsigned MAX_TRIES   = 5,
  parameter int unsigned START_EDGES = 35,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pair_rst_n,
  input  logic [2:0] mode_sel,
  input  logic       ramp_en,
  input  logic [1:0] pwm_in,
  input  logic [1:0] oc_fault,
  input  logic       ot_fault,
  input  logic       uv_fault,
  input  logic       tw_alert,
  output logic [1:0] drv_out,
  output logic [1:0] drv_en,
  output logic       oc_flag_n,
  output logic       tw_flag_n,
  output logic       thr_flag_n
);

  localparam int          NCH       = 2;
  localparam int unsigned RETRY_CYC = retry_cycles(CLK_HZ, RETRY_MS);
  localparam int          TW        = $clog2(MAX_TRIES + 1);
  localparam int          NSYNC     = NCH + 3;

  // Pair release and mode capture.
  logic       rel_q;
  logic       pair_on;
  logic [2:0] mode_q;
  logic       ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      mode_q <= '0;
      ramp_q <= 1'b0;
    end else if (!pair_rst_n) begin
      rel_q  <= 1'b0;
      mode_q <= '0;
      ramp_q <= 1'b0;
    end else begin
      rel_q <= 1'b1;
      if (!rel_q) begin
        mode_q <= mode_sel;
        ramp_q <= ramp_en;
      end
    end
  end

  assign pair_on = rel_q & pair_rst_n;

  // Fault synchronizer.
  logic [NSYNC-1:0] flt_raw, flt_s;
  logic [NCH-1:0]   oc_s;
  logic             ot_s, uv_s, tw_s;

  assign flt_raw = {tw_alert, uv_fault, ot_fault, oc_fault};

  pfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flt_raw),
    .q     (flt_s)
  );

  assign oc_s = flt_s[NCH-1:0];
  assign ot_s = flt_s[NCH];
  assign uv_s = flt_s[NCH+1];
  assign tw_s = flt_s[NCH+2];

  // Startup gate.
  logic started;
  logic start_ok;

  pfg_startup #(.START_EDGES(START_EDGES)) u_startup (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (pair_on),
    .bypass  (ramp_q),
    .pwm_in  (pwm_in[0]),
    .started (started)
  );

  assign start_ok = started & ~mode_reserved(mode_q);

  // Per-channel recovery and output gating.
  logic [NCH-1:0]    ch_fault;
  logic [NCH-1:0]    latched_v;
  logic [NCH*TW-1:0] tries_flat;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign ch_fault[ch] = oc_s[ch] | ot_s | uv_s;

    pfg_chan #(.RETRY_CYC(RETRY_CYC), .MAX_TRIES(MAX_TRIES)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_on    (pair_on),
      .start_ok   (start_ok),
      .latch_mode (mode_latched(mode_q)),
      .fault      (ch_fault[ch]),
      .en         (drv_en[ch]),
      .latched    (latched_v[ch]),
      .tries      (tries_flat[ch*TW +: TW])
    );

    if (ch % 2 == 1) begin : g_second
      assign drv_out[ch] = gate_pwm(drv_en[ch], pwm_in[ch], mode_invert(mode_q));
    end else begin : g_first
      assign drv_out[ch] = gate_pwm(drv_en[ch], pwm_in[ch], 1'b0);
    end
  end

  // Error flags.
  assign oc_flag_n  = ~(|oc_s);
  assign tw_flag_n  = ~tw_s;
  assign thr_flag_n = ~(ot_s | uv_s);

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int unsigned MAX_TRIES = 5,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pair_rst_n,
  input logic          pair_on,
  input logic [2:0]    mode_q,
  input logic          started,
  input logic [1:0]    pwm_in,
  input logic [1:0]    drv_en,
  input logic [1:0]    drv_out,
  input logic [1:0]    latched_v,
  input logic [2*TW-1:0] tries_flat,
  input logic [1:0]    ch_fault
);

  // R1: pair reset turns every output off.
  a_r1_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_rst_n |=> (drv_en == 2'b00));

  // R3: reserved mode never enables.
  a_r3_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_on && mode_q[2]) |-> (drv_en == 2'b00));

  // R5: inversion of the second input.
  a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en[1] && mode_q[1]) |-> (drv_out[1] == !pwm_in[1]));

  // R5: disabled channels drive low.
  a_r5_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_out & ~drv_en) == 2'b00));

  for (genvar i = 0; i < 2; i++) begin : g_ck
    // R4: no channel turns on before startup has completed.
    a_r4_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en[i]) |-> started);

    // R6: a seen fault disables an enabled channel on the next edge.
    a_r6_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en[i] && ch_fault[i]) |=> !drv_en[i]);

    // R7: a latched channel stays latched while the pair is held released.
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_v[i] && pair_rst_n) |=> latched_v[i]);

    // R9: the attempt count is bounded.
    a_r9_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tries_flat[i*TW +: TW] <= TW'(MAX_TRIES));

    // R9: under the retry policy, latch only after the full attempt count.
    a_r9_latch_after_max: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(latched_v[i]) && !mode_q[0]) |-> (tries_flat[i*TW +: TW] == TW'(MAX_TRIES)));
  end

endmodule

bind pair_fault_guard pfg_checker #(.MAX_TRIES(MAX_TRIES)) u_pfg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pair_rst_n (pair_rst_n),
  .pair_on    (pair_on),
  .mode_q     (mode_q),
  .started    (started),
  .pwm_in     (pwm_in),
  .drv_en     (drv_en),
  .drv_out    (drv_out),
  .latched_v  (latched_v),
  .tries_flat (tries_flat),
  .ch_fault   (ch_fault)
);

// File: tb/pair_fault_guard_bench.sv
module pair_fault_guard_bench;

  localparam int unsigned CLK_HZ   = 20_000;
  localparam int unsigned RETRY_MS = 85;
  localparam int          TRIES    = 5;
  localparam int          EDGES    = 35;

  logic       clk = 1'b0;
  logic       rst_n, pair_rst_n, ramp_en, ot_fault, uv_fault, tw_alert;
  logic [2:0] mode_sel;
  logic [1:0] pwm_in, oc_fault;
  logic [1:0] drv_out, drv_en;
  logic       oc_flag_n, tw_flag_n, thr_flag_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pair_fault_guard #(
    .CLK_HZ(CLK_HZ), .RETRY_MS(RETRY_MS), .MAX_TRIES(TRIES), .START_EDGES(EDGES)
  ) u_pair_fault_guard (
    .clk(clk), .rst_n(rst_n), .pair_rst_n(pair_rst_n), .mode_sel(mode_sel),
    .ramp_en(ramp_en), .pwm_in(pwm_in), .oc_fault(oc_fault), .ot_fault(ot_fault),
    .uv_fault(uv_fault), .tw_alert(tw_alert), .drv_out(drv_out), .drv_en(drv_en),
    .oc_flag_n(oc_flag_n), .tw_flag_n(tw_flag_n), .thr_flag_n(thr_flag_n)
  );

  // Retry period, restated from the requirement.
  function automatic int period_cycles();
    return int'(RETRY_MS * (CLK_HZ / 1000));
  endfunction

  // Cycle, counted from fault onset, of the attempt that first sees the fault gone.
  function automatic int resume_at(input int hold);
    int p = period_cycles();
    return (hold / p + 1) * p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pwm0(input int n);
    for (int k = 0; k < n; k++) begin
      pwm_in[0] = 1'b1; cyc(2);
      pwm_in[0] = 1'b0; cyc(2);
    end
  endtask

  task automatic release_pair(input logic [2:0] m, input logic r);
    mode_sel   = m;
    ramp_en    = r;
    pair_rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic hold_pair;
    pair_rst_n = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (180_000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'd1357));
    p = period_cycles();
    rst_n = 1'b0; pair_rst_n = 1'b0; ramp_en = 1'b0; mode_sel = 3'b000;
    pwm_in = 2'b00; oc_fault = 2'b00; ot_fault = 1'b0; uv_fault = 1'b0; tw_alert = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 reset enables", drv_en, 2'b00);
    chk("R10 reset flags", {oc_flag_n, tw_flag_n, thr_flag_n}, 3'b111);

    // R4: edge-counted startup.
    release_pair(3'b000, 1'b0);
    pulse_pwm0(EDGES - 1);
    chk("R4 one edge short", drv_en, 2'b00);
    pulse_pwm0(1);
    chk("R4 after all edges", drv_en, 2'b11);

    // R5: straight pass-through.
    for (int k = 0; k < 8; k++) begin
      pwm_in = 2'($urandom);
      #1;
      chk("R5 pass-through", drv_out, pwm_in);
      cyc(1);
    end

    // R10 and R6: flag latency and channel independence.
    oc_fault = 2'b10;
    cyc(1);
    chk("R10 oc flag one edge", oc_flag_n, 1'b1);
    cyc(1);
    chk("R10 oc flag two edges", oc_flag_n, 1'b0);
    cyc(2);
    chk("R6 only channel 1 off", drv_en, 2'b01);
    oc_fault = 2'b00;
    cyc(p + 40);
    chk("R8 channel 1 back", drv_en, 2'b11);

    tw_alert = 1'b1;
    cyc(2);
    chk("R10 warning flags", {tw_flag_n, thr_flag_n}, 2'b01);
    tw_alert = 1'b0;
    ot_fault = 1'b1;
    cyc(2);
    chk("R10 over-temp flag", thr_flag_n, 1'b0);
    cyc(2);
    chk("R6 shared fault", drv_en, 2'b00);
    ot_fault = 1'b0;
    uv_fault = 1'b1;
    cyc(2);
    chk("R10 under-voltage flag", thr_flag_n, 1'b0);
    uv_fault = 1'b0;
    cyc(p + 60);
    chk("R8 both back", drv_en, 2'b11);

    // R8: directed retry timing.
    oc_fault = 2'b01;
    cyc(10);
    oc_fault = 2'b00;
    cyc(p - 100);
    chk("R8 still waiting", drv_en[0], 1'b0);
    cyc(120);
    chk("R8 resumed", drv_en[0], 1'b1);

    // R8/R9: random fault lengths placed inside a retry period.
    for (int it = 0; it < 4; it++) begin
      int k, r, d, t;
      k = int'($urandom_range(3, 0));
      r = int'($urandom_range(1650, 30));
      d = k * p + r;
      t = resume_at(d);
      cyc(20);
      oc_fault = 2'b01;
      cyc(d);
      oc_fault = 2'b00;
      cyc(t - 20 - d);
      chk("R9 before attempt", drv_en[0], 1'b0);
      cyc(40);
      chk("R8 after attempt", drv_en[0], 1'b1);
    end

    // R9: persistent fault exhausts the attempts.
    oc_fault = 2'b01;
    cyc(TRIES * p + 300);
    oc_fault = 2'b00;
    cyc(2 * p);
    chk("R9 latched off", drv_en, 2'b10);

    // R1: pair reset.
    pwm_in = 2'b11;
    pair_rst_n = 1'b0;
    cyc(1);
    chk("R1 held enables", drv_en, 2'b00);
    chk("R1 held outputs", drv_out, 2'b00);
    cyc(2);

    // R7: latched policy.
    release_pair(3'b001, 1'b1);
    chk("R4 ramp start", drv_en, 2'b11);
    oc_fault = 2'b01;
    cyc(10);
    oc_fault = 2'b00;
    cyc(2 * p + 100);
    chk("R7 stays off", drv_en, 2'b10);
    hold_pair();
    release_pair(3'b001, 1'b1);
    chk("R7 reset toggle", drv_en, 2'b11);

    // R5/R2: inversion and mode capture.
    hold_pair();
    release_pair(3'b010, 1'b1);
    for (int k = 0; k < 6; k++) begin
      pwm_in = 2'($urandom);
      #1;
      chk("R5 inverted", drv_out, {~pwm_in[1], pwm_in[0]});
      cyc(1);
    end
    mode_sel = 3'b000;
    for (int k = 0; k < 4; k++) begin
      pwm_in = 2'($urandom);
      #1;
      chk("R2 mode held", drv_out, {~pwm_in[1], pwm_in[0]});
      cyc(1);
    end

    // R3: reserved modes.
    hold_pair();
    release_pair(3'b110, 1'b1);
    cyc(20);
    chk("R3 reserved ramp", drv_en, 2'b00);
    hold_pair();
    release_pair(3'b100, 1'b0);
    pulse_pwm0(EDGES + 5);
    chk("R3 reserved edges", drv_en, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule